// File: doc/BRIEF.md
# Serial-In Transparent-Latch Output Register

This block is a synchronous model of an eight-stage serial-in, parallel-out register that controls a bank of output drivers. An external shift clock loads one bit per rising edge into the first stage. Each later edge moves the existing bits one stage toward a serial output, so several of these blocks can be chained.

A level-sensitive strobe makes the output latches follow the shift register while it is high. The latches hold their contents while it is low. An active-high disable input forces every driver off without touching the stored bits.

The external shift clock, serial data and strobe are asynchronous to the fast system clock. They pass through two-flop synchronisers, and the shift clock is edge-detected before any shift happens.

Top module: `sipo_drive_latch`

## Requirements
- R1: A synchronous active-high reset clears the shift register and the latches, so `drive` is all zeros and `sdo` is 0 once reset has been seen.
- R2: On each rising edge of `shclk`, the value of `sdi` at that edge enters stage 0, and stage i moves to stage i+1. Bit i of `drive` reflects stage i.
- R3: `sdo` always equals the last stage. After eight shifts, it shows the first bit that was shifted in.
- R4: While `strobe` is high, each latch follows its shift-register stage. Every shift is therefore visible on `drive` when `blank` is 0.
- R5: While `strobe` is low, the latches hold their contents, and shifts do not change `drive`.
- R6: While `blank` is 1, every bit of `drive` is 0 (driver off). The latches and shift register stay unchanged, and a strobe taken while blanked still loads the latches.
- R7: While `blank` is 0, bit i of `drive` equals latch bit i, where 1 means the driver is on.
- R8: Holding `shclk` high for many system clocks shifts exactly once. A falling edge of `shclk` does not shift.
- R9: With `strobe` held high and `blank` held at 1 during a full load, `drive` stays 0 throughout. Lowering `blank` afterwards shows the final pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in, asynchronous |
| shclk | input | 1 | External shift clock, asynchronous |
| strobe | input | 1 | Latch transparency control, asynchronous |
| blank | input | 1 | Active-high output disable |
| drive | output | WIDTH | Driver controls, 1 = on |
| sdo | output | 1 | Serial data out from the last stage |

## Verification
A rise on `shclk` is seen by the shift register on the third system clock edge. It reaches `drive` on the fourth edge when the latch is transparent. A rise on `strobe` loads the latches on the third edge, and `blank` acts on `drive` in the same cycle.

The driver tasks stamp each expected item with the cycle it is due. For shifts and strobes that is the fourth edge, after every register has settled. For `blank` it is the current cycle. The monitor compares each item at the falling edge of its due cycle. A second item seven cycles after a long `shclk` pulse confirms that no extra shift has occurred.

// File: rtl/sipo_drive_latch.sv
module sipo_drive_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdi,
  input  logic             shclk,
  input  logic             strobe,
  input  logic             blank,
  output logic [WIDTH-1:0] drive,
  output logic             sdo
);

  logic [1:0] shc_sync, sdi_sync, stb_sync;
  logic       shc_prev;
  logic [WIDTH-1:0] shreg, latch;
  logic       shift_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      shc_sync <= '0;
      sdi_sync <= '0;
      stb_sync <= '0;
      shc_prev <= 1'b0;
    end else begin
      shc_sync <= {shc_sync[0], shclk};
      sdi_sync <= {sdi_sync[0], sdi};
      stb_sync <= {stb_sync[0], strobe};
      shc_prev <= shc_sync[1];
    end
  end

  assign shift_edge = shc_sync[1] & ~shc_prev;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else if (shift_edge) shreg <= {shreg[WIDTH-2:0], sdi_sync[1]};
  end

  always_ff @(posedge clk) begin
    if (rst) latch <= '0;
    else if (stb_sync[1]) latch <= shreg;
  end

  assign drive = blank ? '0 : latch;
  assign sdo   = shreg[WIDTH-1];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (shreg == '0 && latch == '0)); // R1
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    shift_edge |=> shreg[WIDTH-1:1] == $past(shreg[WIDTH-2:0])); // R2
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_edge |=> $stable(shreg)); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb_sync[1] |=> $stable(latch)); // R5
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
    blank |-> drive == '0); // R6

endmodule

// File: tb/sipo_drive_latch_test.sv
module sipo_drive_latch_test;
  logic clk = 0, rst = 1, sdi = 0, shclk = 0, strobe = 0, blank = 0;
  logic [7:0] drive;
  logic sdo;

  sipo_drive_latch #(.WIDTH(8)) uut (
    .clk(clk), .rst(rst), .sdi(sdi), .shclk(shclk), .strobe(strobe),
    .blank(blank), .drive(drive), .sdo(sdo));

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    logic [7:0] drv;
    logic       so;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_sr = 0, m_lat = 0;
  bit m_stb = 0, m_blank = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int due, string req);
    item_t it;
    it.due = due;
    it.drv = m_blank ? 8'h00 : m_lat;
    it.so  = m_sr[7];
    it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (drive !== it.drv || sdo !== it.so) begin
        fails++;
        $display("FAIL %s: drive=%b sdo=%b expected drive=%b sdo=%b",
                 it.req, drive, sdo, it.drv, it.so);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst = 1;
    m_sr = 0; m_lat = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    push(cyc, "R1 reset");
    repeat (2) @(posedge clk);
  endtask

  task automatic shift_bit(bit b, string req);
    @(posedge clk); #1;
    sdi = b; shclk = 1;
    m_sr = {m_sr[6:0], b};
    if (m_stb) m_lat = m_sr;
    push(cyc + 4, req);
    push(cyc + 7, "R8 single shift per edge");
    repeat (5) @(posedge clk);
    #1 shclk = 0;
    repeat (5) @(posedge clk);
  endtask

  task automatic shift_byte(logic [7:0] v, string req);
    for (int i = 7; i >= 0; i--) shift_bit(v[i], req);
  endtask

  task automatic set_strobe(bit v, string req);
    @(posedge clk); #1;
    strobe = v; m_stb = v;
    if (v) m_lat = m_sr;
    push(cyc + 4, req);
    repeat (6) @(posedge clk);
  endtask

  task automatic set_blank(bit v, string req);
    @(posedge clk); #1;
    blank = v; m_blank = v;
    push(cyc, req);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    do_reset();
    shift_byte(8'b1011_0010, "R2/R3 shift, strobe low R5");
    set_strobe(1, "R4 strobe copies A, R7");
    set_strobe(0, "R5 strobe low");
    shift_byte(8'b0110_1101, "R5 latch holds A while shifting B, R3");
    set_blank(1, "R6 blank forces off");
    set_strobe(1, "R6 strobe under blank");
    set_strobe(0, "R6 strobe released");
    set_blank(0, "R7 latch B shown after unblank");
    set_strobe(1, "R4 transparent");
    shift_byte(8'b1100_0101, "R4 latch follows each shift");
    set_blank(1, "R9 blank before load");
    shift_byte(8'b0011_1001, "R9 outputs stay off during load");
    set_blank(0, "R9 final pattern shown");
    set_strobe(0, "R5 close latch");
    do_reset();
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule